// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches a set of general-purpose pin inputs, grouped into banks of up to 32 lines, and turns selected pin activity into a single interrupt request. Every line has a 4-bit trigger code. The code picks a rising edge, a falling edge, either edge, an active-high level or an active-low level. Each pin first passes through a two-flop synchronizer. The detector then compares the synchronized value with its value one cycle earlier. A detected event sets that line's bit in the bank's status register.

Software accesses the block through a flat 32-bit register port. A write strobe carries the address and data in a single cycle. The read data is a combinational function of the address. Each bank has its own 0x20-byte window starting at 0x200. In each window, four words hold the trigger codes, one word holds the enable mask and one word holds the pending status. The status register is write-one-to-clear. The interrupt output is high while any bank has a status bit set whose enable bit is also set.

A typical service routine reads each bank's status, writes the same value back to acknowledge it, and then handles the lines. To retire a line, software clears its enable bit and then writes its status bit. The block has no streaming data path, so no valid/ready back-pressure applies.

Top module: `pev_irq_ctrl`

## Requirements
- R1: After reset, every mode word, enable register and status register reads 0 and `irq` is low.
- R2: Bank b's registers sit at 0x200 + 0x20*b. Mode word k is at offset 4*k (k = 0..3). Line n's code is in word n/8 at bits (n mod 8)*4 +: 4, and all four bits read back as written. The enable register is at offset 0x10 and the status register at offset 0x14, with bit n belonging to line n. Fields and bits for lines at or above LINES read 0.
- R3: Code 0 (rising) sets the status bit when the pin goes from 0 to 1. The bit becomes readable three clock edges after the pin changes and is not yet set after two. A 1-to-0 change sets nothing.
- R4: Code 1 (falling) sets the status bit on a 1-to-0 pin change, with the same latency as R3, and sets nothing on a 0-to-1 change.
- R5: Code 4 (both) sets the status bit on every change of the pin in either direction.
- R6: Code 2 (high) and code 3 (low) set the status bit on every cycle that the synchronized pin is at the active level. A clear written while the level persists leaves the bit set. Once the level has gone inactive, the bit stays set until it is cleared.
- R7: Codes 5 to 15 never set a status bit, whatever the pin does.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Clearing works whether the line is enabled or not. A status bit never falls without such a write.
- R9: Status bits latch events whether or not the line is enabled. `irq` is the OR, over all banks and lines, of status AND enable, and it is low whenever all enables are 0.
- R10: When a clear write and a new event hit the same status bit in the same cycle, the bit stays set.
- R11: A write outside the implemented windows or registers (a bank index at or above NUM_BANKS, an offset other than those in R2, or an address below 0x200) changes nothing, and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational in `reg_addr` |
| pin_in | input | NUM_BANKS*LINES | Raw pin levels; bank b line n is bit b*LINES+n |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_BANKS = 2 and LINES = 12. With those values, bank 1's window at 0x220 is live and bank 2's window at 0x240 is an unimplemented address. The partly filled mode word 1 and the empty word 2 show that fields for missing lines read zero, and writing all ones to the enable register shows the mask at the 12-bit width. Because there are two banks, the interrupt path is checked from a bank other than bank 0. The timing of each edge mode, and the case where a clear and an event arrive in the same cycle, are checked against clock edges counted from the pin change.

// File: rtl/pev_pkg.sv
`timescale 1ns/1ps
package pev_pkg;
  localparam logic [3:0] TRIG_RISE = 4'd0;
  localparam logic [3:0] TRIG_FALL = 4'd1;
  localparam logic [3:0] TRIG_HIGH = 4'd2;
  localparam logic [3:0] TRIG_LOW  = 4'd3;
  localparam logic [3:0] TRIG_BOTH = 4'd4;

  localparam logic [4:0] OFS_ENABLE = 5'h10;
  localparam logic [4:0] OFS_STATUS = 5'h14;
  localparam int unsigned FIELDS_PER_WORD = 8;
  localparam int unsigned FIELD_W = 4;

  // one trigger decision for one line
  function automatic logic trig_hit(logic [3:0] code, logic cur, logic prev);
    case (code)
      TRIG_RISE: trig_hit = cur & ~prev;
      TRIG_FALL: trig_hit = ~cur & prev;
      TRIG_HIGH: trig_hit = cur;
      TRIG_LOW:  trig_hit = ~cur;
      TRIG_BOTH: trig_hit = cur ^ prev;
      default:   trig_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pev_sync.sv
`timescale 1ns/1ps
module pev_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [W-1:0] meta_q, stab_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
      last_q <= stab_q;
    end
  end

  assign dout  = stab_q;
  assign dprev = last_q;
endmodule

// File: rtl/pev_detect.sv
`timescale 1ns/1ps
module pev_detect
  import pev_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic [LINES*FIELD_W-1:0] codes,
  input  logic [LINES-1:0]         cur,
  input  logic [LINES-1:0]         prev,
  output logic [LINES-1:0]         hit
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign hit[n] = trig_hit(codes[n*FIELD_W +: FIELD_W], cur[n], prev[n]);
  end
endmodule

// File: rtl/pev_bank.sv
`timescale 1ns/1ps
module pev_bank
  import pev_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [4:0]       ofs,
  input  logic [31:0]      wdata,
  input  logic [LINES-1:0] cur,
  input  logic [LINES-1:0] prev,
  output logic [31:0]      rdata,
  output logic [LINES-1:0] status,
  output logic [LINES-1:0] enable
);
  localparam int CODE_BITS = LINES * FIELD_W;
  localparam int PAD_BITS  = 4 * 32;

  logic [CODE_BITS-1:0] code_q;
  logic [LINES-1:0]     enable_q, status_q, hit, clr;
  logic [PAD_BITS-1:0]  code_pad;
  logic                 wr_code, wr_en, wr_st;

  assign wr_code = we && sel && (ofs[4] == 1'b0) && (ofs[1:0] == 2'b00);
  assign wr_en   = we && sel && (ofs == OFS_ENABLE);
  assign wr_st   = we && sel && (ofs == OFS_STATUS);
  assign clr     = wr_st ? wdata[LINES-1:0] : '0;

  pev_detect #(.LINES(LINES)) det_i (
    .codes (code_q),
    .cur   (cur),
    .prev  (prev),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= '0;
      enable_q <= '0;
      status_q <= '0;
    end else begin
      for (int n = 0; n < LINES; n++) begin
        if (wr_code && (ofs[3:2] == 2'(n / FIELDS_PER_WORD)))
          code_q[n*FIELD_W +: FIELD_W] <= wdata[(n % FIELDS_PER_WORD)*FIELD_W +: FIELD_W];
      end
      if (wr_en)
        enable_q <= wdata[LINES-1:0];
      // a fresh event outranks a clear of the same bit
      status_q <= (status_q & ~clr) | hit;
    end
  end

  assign code_pad = PAD_BITS'(code_q);

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (ofs)
        5'h00, 5'h04, 5'h08, 5'h0C: rdata = code_pad[32*ofs[3:2] +: 32];
        OFS_ENABLE:                 rdata = 32'(enable_q);
        OFS_STATUS:                 rdata = 32'(status_q);
        default:                    rdata = '0;
      endcase
    end
  end

  assign status = status_q;
  assign enable = enable_q;
endmodule

// File: rtl/pev_irq_ctrl.sv
`timescale 1ns/1ps
module pev_irq_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32,
  parameter int AW        = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [AW-1:0]              reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_BANKS*LINES-1:0] pin_in,
  output logic                       irq
);
  localparam int TOTAL = NUM_BANKS * LINES;

  logic [TOTAL-1:0]               pin_cur, pin_prev;
  logic [TOTAL-1:0]               status_all, enable_all;
  logic [NUM_BANKS-1:0][31:0]     rd_b;
  logic                           in_win;
  logic [3:0]                     bank_idx;
  logic [4:0]                     ofs;

  // window 0x200..0x3FF, 32 bytes per bank
  assign in_win   = (reg_addr[AW-1:9] == (AW-9)'(1));
  assign bank_idx = reg_addr[8:5];
  assign ofs      = reg_addr[4:0];

  pev_sync #(.W(TOTAL)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (pin_cur),
    .dprev (pin_prev)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pev_bank #(.LINES(LINES)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (in_win && (bank_idx == 4'(b))),
      .we     (reg_we),
      .ofs    (ofs),
      .wdata  (reg_wdata),
      .cur    (pin_cur[b*LINES +: LINES]),
      .prev   (pin_prev[b*LINES +: LINES]),
      .rdata  (rd_b[b]),
      .status (status_all[b*LINES +: LINES]),
      .enable (enable_all[b*LINES +: LINES])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      reg_rdata = reg_rdata | rd_b[b];
  end

  assign irq = |(status_all & enable_all);
endmodule

// File: rtl/pev_irq_ctrl_chk.sv
`timescale 1ns/1ps
module pev_irq_ctrl_chk #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32,
  parameter int AW        = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [AW-1:0]              reg_addr,
  input logic [31:0]                reg_wdata,
  input logic                       irq,
  input logic [NUM_BANKS*LINES-1:0] status_all,
  input logic [NUM_BANKS*LINES-1:0] enable_all
);
  localparam logic [31:0] EN_MASK = 32'((64'd1 << LINES) - 64'd1);

  logic any_status_wr, bank0_en_wr;
  assign any_status_wr = reg_we && (reg_addr[AW-1:9] == (AW-9)'(1)) && (reg_addr[4:0] == 5'h14);
  assign bank0_en_wr   = reg_we && (reg_addr == AW'('h210));

  // R9: no request while every line is masked
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_all == '0) |-> !irq);

  // R9: a request needs some pending status
  p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_all != '0));

  // R8: status bits fall only through a status write
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_status_wr |=> ((status_all & $past(status_all)) == $past(status_all)));

  // R2: enable register takes the written value, masked to LINES
  p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank0_en_wr |=> (32'(enable_all[LINES-1:0]) == ($past(reg_wdata) & EN_MASK)));
endmodule

bind pev_irq_ctrl pev_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .LINES(LINES), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq        (irq),
  .status_all (status_all),
  .enable_all (enable_all)
);

// File: tb/pev_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pev_irq_ctrl_tb_top;
  localparam int NB = 2;
  localparam int LN = 12;
  localparam int AW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NB*LN-1:0]  pin_in = '0;
  logic              irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pev_irq_ctrl #(.NUM_BANKS(NB), .LINES(LN), .AW(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h200, v); chk("R1 mode word", v, 0);
    rd(12'h210, v); chk("R1 enable", v, 0);
    rd(12'h214, v); chk("R1 status b0", v, 0);
    rd(12'h234, v); chk("R1 status b1", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(12'h200, 32'h4321_0432); rd(12'h200, v); chk("R2 word0 readback", v, 32'h4321_0432);
    wr(12'h204, 32'hFFFF_FFFF); rd(12'h204, v); chk("R2 word1 partial", v, 32'h0000_FFFF);
    wr(12'h208, 32'hFFFF_FFFF); rd(12'h208, v); chk("R2 word2 empty", v, 0);
    wr(12'h210, 32'hFFFF_FFFF); rd(12'h210, v); chk("R2 enable mask", v, 32'h0000_0FFF);
    wr(12'h230, 32'h0000_0005); rd(12'h230, v); chk("R2 bank1 enable", v, 32'h5);
    rd(12'h210, v); chk("R2 bank0 enable kept", v, 32'h0000_0FFF);
    wr(12'h200, 0); wr(12'h204, 0); wr(12'h210, 0); wr(12'h230, 0);
    wr(12'h214, 32'hFFFF_FFFF);
    rd(12'h214, v); chk("R2 status cleared", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    pin_in[0] = 1'b1;
    tick(2); rd(12'h214, v); chk("R3 not yet after two edges", v & 32'h1, 0);
    tick(1); rd(12'h214, v); chk("R3 set after three edges", v & 32'h1, 32'h1);
    wr(12'h214, 32'h1);
    pin_in[0] = 1'b0;
    tick(4); rd(12'h214, v); chk("R3 fall ignored", v & 32'h1, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(12'h200, 32'h0001_0000);
    pin_in[4] = 1'b1;
    tick(4); rd(12'h214, v); chk("R4 rise ignored", v & 32'h10, 0);
    pin_in[4] = 1'b0;
    tick(2); rd(12'h214, v); chk("R4 not yet", v & 32'h10, 0);
    tick(1); rd(12'h214, v); chk("R4 set on fall", v & 32'h10, 32'h10);
    wr(12'h214, 32'h10); wr(12'h200, 0);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(12'h200, 32'h0040_0000);
    pin_in[5] = 1'b1;
    tick(4); rd(12'h214, v); chk("R5 set on rise", v & 32'h20, 32'h20);
    wr(12'h214, 32'h20);
    rd(12'h214, v); chk("R5 cleared", v & 32'h20, 0);
    pin_in[5] = 1'b0;
    tick(4); rd(12'h214, v); chk("R5 set on fall", v & 32'h20, 32'h20);
    wr(12'h214, 32'h20); wr(12'h200, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(12'h200, 32'h0000_0200);
    tick(3); rd(12'h214, v); chk("R6 high idle", v & 32'h4, 0);
    pin_in[2] = 1'b1;
    tick(4); rd(12'h214, v); chk("R6 high set", v & 32'h4, 32'h4);
    wr(12'h214, 32'h4);
    rd(12'h214, v); chk("R6 clear blocked by level", v & 32'h4, 32'h4);
    pin_in[2] = 1'b0;
    tick(4); rd(12'h214, v); chk("R6 stays after level drops", v & 32'h4, 32'h4);
    wr(12'h214, 32'h4);
    rd(12'h214, v); chk("R6 clear after level drops", v & 32'h4, 0);
    wr(12'h200, 32'h0000_0300);
    tick(2); rd(12'h214, v); chk("R6 low set", v & 32'h4, 32'h4);
    pin_in[2] = 1'b1;
    tick(4); wr(12'h214, 32'h4);
    rd(12'h214, v); chk("R6 low cleared when high", v & 32'h4, 0);
    wr(12'h200, 0);
    pin_in[2] = 1'b0;
    tick(4); wr(12'h214, 32'h4);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    for (int c = 5; c < 16; c++) begin
      wr(12'h200, 32'(c) << 24);
      pin_in[6] = 1'b1; tick(4);
      pin_in[6] = 1'b0; tick(4);
      rd(12'h214, v); chk($sformatf("R7 code %0d silent", c), v & 32'h40, 0);
    end
    wr(12'h200, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    pin_in[8] = 1'b1; pin_in[9] = 1'b1;
    tick(4); rd(12'h214, v); chk("R8 two pending", v & 32'h300, 32'h300);
    wr(12'h214, 32'h0);
    rd(12'h214, v); chk("R8 zero write keeps", v & 32'h300, 32'h300);
    wr(12'h214, 32'h100);
    rd(12'h214, v); chk("R8 one bit cleared", v & 32'h300, 32'h200);
    wr(12'h214, 32'h200);
    rd(12'h214, v); chk("R8 clear while disabled", v & 32'h300, 0);
    pin_in[8] = 1'b0; pin_in[9] = 1'b0; tick(4);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pin_in[LN+3] = 1'b1;
    tick(4); rd(12'h234, v); chk("R9 latched while masked", v, 32'h8);
    chk("R9 irq masked", 32'(irq), 0);
    wr(12'h210, 32'h8);
    chk("R9 other bank enable no irq", 32'(irq), 0);
    wr(12'h230, 32'h8);
    chk("R9 irq on enable", 32'(irq), 1);
    wr(12'h234, 32'h8);
    rd(12'h234, v); chk("R8 clear while enabled", v, 0);
    chk("R9 irq drops after clear", 32'(irq), 0);
    wr(12'h230, 0); wr(12'h210, 0);
    pin_in[LN+3] = 1'b0; tick(4);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pin_in[7] = 1'b1;
    tick(1);
    wr(12'h214, 32'h80);
    rd(12'h214, v); chk("R10 event beats clear", v & 32'h80, 32'h80);
    wr(12'h214, 32'h80);
    rd(12'h214, v); chk("R10 later clear works", v & 32'h80, 0);
    pin_in[7] = 1'b0; tick(4);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h250, 32'hFFFF_FFFF); rd(12'h250, v); chk("R11 absent bank reads 0", v, 0);
    wr(12'h218, 32'hFFFF_FFFF); rd(12'h218, v); chk("R11 spare offset reads 0", v, 0);
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, v); chk("R11 low address reads 0", v, 0);
    wr(12'h212, 32'hFFFF_FFFF);
    rd(12'h210, v); chk("R11 bank0 enable untouched", v, 0);
    rd(12'h230, v); chk("R11 bank1 enable untouched", v, 0);
    chk("R11 irq quiet", 32'(irq), 0);
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_reserved();
    t_w1c();
    t_irq();
    t_race();
    t_unmapped();
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule